// File: doc/BRIEF.md
# Queued DMA Command Engine

This block takes transfer descriptors from a small register window, holds them in a short command queue and executes them one after another over a word-wide memory request interface. Software loads a source address, a destination address and the two lengths (counted in 32-bit words). Writing the destination length is the trigger that captures all four values as one command.

Each command is worked off in bounded pieces. A piece is first read from memory into a local buffer. If the loopback control bit is set, the same piece is then written out to the destination. When nothing is left of either length, the command leaves the queue and the completion bits in the interrupt status register are set. A single level interrupt reports every status bit that the mask leaves open.

Register offsets (byte addresses on `cfg_addr`): 0x00 source address, 0x04 destination address, 0x08 source length, 0x0C destination length, 0x10 interrupt status, 0x14 interrupt mask, 0x18 queue status (read only), 0x1C miscellaneous control.

Top module: `dmaq_engine`

## Requirements
- R1: After reset, interrupt status (0x10) reads 0x88020000, the mask (0x14) reads 0xFFFFFFFF, queue status (0x18) reads 0x40000000 and `irq` is low.
- R2: The length registers (0x08 source, 0x0C destination) keep only bits 26:0 of a write; bits 31:27 read as zero.
- R3: A write to 0x0C enqueues one command built from the current 0x00, 0x04 and 0x08 contents and the newly written length. Both addresses have bits 1:0 cleared, and both lengths are multiplied by 4 to give bytes.
- R4: The engine splits a command into pieces of min(1024 bytes, remaining source bytes). In loopback the piece is also no larger than the remaining destination bytes. All read beats of a piece, at ascending word addresses, complete before any of its write beats.
- R5: With loopback (bit 4 of 0x1C, taken at the start of each piece), each piece is written to consecutive destination words with the data read, and the destination counters advance. Without loopback, no write beats occur.
- R6: When both remaining lengths of the head command are zero, interrupt status bits 13 and 12 are set and the command is removed. Commands execute in the order they were enqueued. A command with both lengths zero completes with no memory beats.
- R7: When a command still has a nonzero remaining length but its next piece size is zero, it is removed, status bit 15 is set, and bits 13 and 12 are not set.
- R8: The queue holds 4 commands, counting the one in progress. Queue status bit 31 means full and bit 30 means empty. A trigger write while the queue is full drops that command and sets status bit 14.
- R9: Writing 1 to an interrupt status bit clears it. Writing 0 leaves it unchanged.
- R10: `irq` is high exactly when some status bit is set whose mask bit is clear.
- R11: Each memory request holds its valid level, word address (bits 1:0 zero) and write data stable until ready is seen. A read and a write are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| irq | output | 1 | Level interrupt |
| rd_valid | output | 1 | Memory read request |
| rd_addr | output | 32 | Read word address |
| rd_ready | input | 1 | Read accepted; `rd_data` valid this cycle |
| rd_data | input | 32 | Read data |
| wr_valid | output | 1 | Memory write request |
| wr_addr | output | 32 | Write word address |
| wr_data | output | 32 | Write data |
| wr_ready | input | 1 | Write accepted |

## Verification
The bound checker watches the handshake rules of both memory channels every cycle: stability while stalled, alignment, and no read and write at once. It also checks that queue full and empty never coincide, that each completion, error or overflow event lands in the matching status bit one cycle later, and that an all-ones mask silences the interrupt. The piece sizes, the read-before-write order inside a piece, the data carried to the destination, the order of commands, the dropped fifth command and the register readback only show up in the bench scenarios. There, every memory beat is compared against a beat list derived from the requirements.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
    localparam int LEN_W  = 27;
    localparam int BLEN_W = LEN_W + 2;

    typedef struct packed {
        logic [31:0]       src;
        logic [31:0]       dst;
        logic [BLEN_W-1:0] slen;
        logic [BLEN_W-1:0] dlen;
    } dmaq_cmd_t;

    localparam logic [7:0] A_SRC   = 8'h00;
    localparam logic [7:0] A_DST   = 8'h04;
    localparam logic [7:0] A_SLEN  = 8'h08;
    localparam logic [7:0] A_DLEN  = 8'h0C;
    localparam logic [7:0] A_STAT  = 8'h10;
    localparam logic [7:0] A_MASK  = 8'h14;
    localparam logic [7:0] A_QSTAT = 8'h18;
    localparam logic [7:0] A_MISC  = 8'h1C;

    localparam int B_PDONE = 12;
    localparam int B_DONE  = 13;
    localparam int B_QOVF  = 14;
    localparam int B_CERR  = 15;
    localparam int B_LOOP  = 4;

    localparam logic [31:0] STAT_RST = 32'h8802_0000;
endpackage

// File: rtl/dmaq_cmd_fifo.sv
module dmaq_cmd_fifo
    import dmaq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  dmaq_cmd_t push_cmd,
    input  logic      pop,
    output dmaq_cmd_t head,
    output logic      full,
    output logic      empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t  s_d, s_q;
    dmaq_cmd_t slots [DEPTH];
    logic      do_push, do_pop;

    assign full    = (s_q.cnt == CW'(DEPTH));
    assign empty   = (s_q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slots[s_q.rp];

    always_comb begin
        s_d = s_q;
        if (do_push) s_d.wp = (s_q.wp == PW'(DEPTH - 1)) ? '0 : s_q.wp + 1'b1;
        if (do_pop)  s_d.rp = (s_q.rp == PW'(DEPTH - 1)) ? '0 : s_q.rp + 1'b1;
        if (do_push && !do_pop)      s_d.cnt = s_q.cnt + 1'b1;
        else if (do_pop && !do_push) s_d.cnt = s_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) slots[s_q.wp] <= push_cmd;
    end
endmodule

// File: rtl/dmaq_chunk_buf.sv
module dmaq_chunk_buf #(
    parameter int WORDS = 256,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [31:0]   wdata,
    input  logic [IW-1:0] ridx,
    output logic [31:0]   rdata
);
    logic [31:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (we) cells[widx] <= wdata;
    end

    assign rdata = cells[ridx];
endmodule

// File: rtl/dmaq_mover.sv
module dmaq_mover
    import dmaq_pkg::*;
#(
    parameter int CHUNK_BYTES = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  dmaq_cmd_t   cmd,
    input  logic        loopback,
    output logic        cmd_pop,
    output logic        cmd_done,
    output logic        cmd_err,
    output logic        rd_valid,
    output logic [31:0] rd_addr,
    input  logic        rd_ready,
    input  logic [31:0] rd_data,
    output logic        wr_valid,
    output logic [31:0] wr_addr,
    output logic [31:0] wr_data,
    input  logic        wr_ready
);
    localparam int WORDS = CHUNK_BYTES / 4;
    localparam int IW    = $clog2(WORDS);

    typedef enum logic [1:0] {S_IDLE, S_PLAN, S_READ, S_WRITE} mv_state_e;

    typedef struct packed {
        mv_state_e         st;
        logic [31:0]       src;
        logic [31:0]       dst;
        logic [BLEN_W-1:0] srem;
        logic [BLEN_W-1:0] drem;
        logic              lb;
        logic [IW-1:0]     idx;
        logic [IW-1:0]     last;
    } mv_t;

    mv_t               m_d, m_q;
    logic [BLEN_W-1:0] piece, piece_wm1;

    dmaq_chunk_buf #(.WORDS(WORDS)) u_buf (
        .clk  (clk),
        .we   (m_q.st == S_READ && rd_ready),
        .widx (m_q.idx),
        .wdata(rd_data),
        .ridx (m_q.idx),
        .rdata(wr_data)
    );

    always_comb begin
        piece = m_q.srem;
        if (loopback && m_q.drem < piece) piece = m_q.drem;
        if (piece > BLEN_W'(CHUNK_BYTES)) piece = BLEN_W'(CHUNK_BYTES);
        piece_wm1 = (piece >> 2) - BLEN_W'(1);

        m_d      = m_q;
        cmd_pop  = 1'b0;
        cmd_done = 1'b0;
        cmd_err  = 1'b0;
        case (m_q.st)
            S_IDLE: if (cmd_valid) begin
                m_d.src  = cmd.src;
                m_d.dst  = cmd.dst;
                m_d.srem = cmd.slen;
                m_d.drem = cmd.dlen;
                m_d.st   = S_PLAN;
            end
            S_PLAN: begin
                if (m_q.srem == '0 && m_q.drem == '0) begin
                    cmd_pop  = 1'b1;
                    cmd_done = 1'b1;
                    m_d.st   = S_IDLE;
                end else if (piece == '0) begin
                    cmd_pop = 1'b1;
                    cmd_err = 1'b1;
                    m_d.st  = S_IDLE;
                end else begin
                    m_d.lb   = loopback;
                    m_d.idx  = '0;
                    m_d.last = piece_wm1[IW-1:0];
                    m_d.st   = S_READ;
                end
            end
            S_READ: if (rd_ready) begin
                m_d.src  = m_q.src + 32'd4;
                m_d.srem = m_q.srem - BLEN_W'(4);
                m_d.idx  = m_q.idx + 1'b1;
                if (m_q.idx == m_q.last) begin
                    m_d.idx = '0;
                    m_d.st  = m_q.lb ? S_WRITE : S_PLAN;
                end
            end
            default: if (wr_ready) begin
                m_d.dst  = m_q.dst + 32'd4;
                m_d.drem = m_q.drem - BLEN_W'(4);
                m_d.idx  = m_q.idx + 1'b1;
                if (m_q.idx == m_q.last) m_d.st = S_PLAN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '{st: S_IDLE, default: '0};
        else        m_q <= m_d;
    end

    assign rd_valid = (m_q.st == S_READ);
    assign rd_addr  = m_q.src;
    assign wr_valid = (m_q.st == S_WRITE);
    assign wr_addr  = m_q.dst;
endmodule

// File: rtl/dmaq_engine.sv
module dmaq_engine
    import dmaq_pkg::*;
#(
    parameter int QDEPTH      = 4,
    parameter int CHUNK_BYTES = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [7:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        irq,
    output logic        rd_valid,
    output logic [31:0] rd_addr,
    input  logic        rd_ready,
    input  logic [31:0] rd_data,
    output logic        wr_valid,
    output logic [31:0] wr_addr,
    output logic [31:0] wr_data,
    input  logic        wr_ready
);
    typedef struct packed {
        logic [31:0]      src_addr;
        logic [31:0]      dst_addr;
        logic [LEN_W-1:0] src_len;
        logic [LEN_W-1:0] dst_len;
        logic [31:0]      stat;
        logic [31:0]      mask;
        logic             loop_en;
    } regs_t;

    regs_t     r_d, r_q;
    dmaq_cmd_t new_cmd, head_cmd;
    logic      cmd_push, q_full, q_empty;
    logic      mv_pop, mv_done, mv_err;

    assign cmd_push = cfg_we && (cfg_addr == A_DLEN);

    assign new_cmd.src  = {r_q.src_addr[31:2], 2'b00};
    assign new_cmd.dst  = {r_q.dst_addr[31:2], 2'b00};
    assign new_cmd.slen = {r_q.src_len, 2'b00};
    assign new_cmd.dlen = {cfg_wdata[LEN_W-1:0], 2'b00};

    dmaq_cmd_fifo #(.DEPTH(QDEPTH)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (cmd_push),
        .push_cmd(new_cmd),
        .pop     (mv_pop),
        .head    (head_cmd),
        .full    (q_full),
        .empty   (q_empty)
    );

    dmaq_mover #(.CHUNK_BYTES(CHUNK_BYTES)) u_mover (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(!q_empty),
        .cmd      (head_cmd),
        .loopback (r_q.loop_en),
        .cmd_pop  (mv_pop),
        .cmd_done (mv_done),
        .cmd_err  (mv_err),
        .rd_valid (rd_valid),
        .rd_addr  (rd_addr),
        .rd_ready (rd_ready),
        .rd_data  (rd_data),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_ready (wr_ready)
    );

    always_comb begin
        r_d = r_q;
        if (cfg_we) begin
            case (cfg_addr)
                A_SRC:   r_d.src_addr = cfg_wdata;
                A_DST:   r_d.dst_addr = cfg_wdata;
                A_SLEN:  r_d.src_len  = cfg_wdata[LEN_W-1:0];
                A_DLEN:  r_d.dst_len  = cfg_wdata[LEN_W-1:0];
                A_STAT:  r_d.stat     = r_q.stat & ~cfg_wdata;
                A_MASK:  r_d.mask     = cfg_wdata;
                A_MISC:  r_d.loop_en  = cfg_wdata[B_LOOP];
                default: ;
            endcase
        end
        if (cmd_push && q_full) r_d.stat[B_QOVF] = 1'b1;
        if (mv_done) begin
            r_d.stat[B_DONE]  = 1'b1;
            r_d.stat[B_PDONE] = 1'b1;
        end
        if (mv_err) r_d.stat[B_CERR] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{stat: STAT_RST, mask: '1, default: '0};
        else        r_q <= r_d;
    end

    always_comb begin
        case (cfg_addr)
            A_SRC:   cfg_rdata = r_q.src_addr;
            A_DST:   cfg_rdata = r_q.dst_addr;
            A_SLEN:  cfg_rdata = {{(32-LEN_W){1'b0}}, r_q.src_len};
            A_DLEN:  cfg_rdata = {{(32-LEN_W){1'b0}}, r_q.dst_len};
            A_STAT:  cfg_rdata = r_q.stat;
            A_MASK:  cfg_rdata = r_q.mask;
            A_QSTAT: cfg_rdata = {q_full, q_empty, 30'd0};
            A_MISC:  cfg_rdata = {27'd0, r_q.loop_en, 4'd0};
            default: cfg_rdata = '0;
        endcase
    end

    assign irq = |(r_q.stat & ~r_q.mask);
endmodule

// File: rtl/dmaq_engine_chk.sv
module dmaq_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_valid,
    input logic [31:0] rd_addr,
    input logic        rd_ready,
    input logic        wr_valid,
    input logic [31:0] wr_addr,
    input logic [31:0] wr_data,
    input logic        wr_ready,
    input logic        irq,
    input logic [31:0] stat,
    input logic [31:0] mask,
    input logic        q_full,
    input logic        q_empty,
    input logic        cmd_push,
    input logic        mv_done,
    input logic        mv_err
);
    p_rw_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_valid));
    p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
    p_wr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
    p_rd_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_addr[1:0] == 2'b00);
    p_wr_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_addr[1:0] == 2'b00);
    p_full_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_full && q_empty));
    p_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_push && q_full |=> stat[14]);
    p_done_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mv_done |=> stat[13] && stat[12]);
    p_err_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mv_err |=> stat[15]);
    p_done_xor_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mv_done && mv_err));
    p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 32'hFFFF_FFFF) |-> !irq);
endmodule

bind dmaq_engine dmaq_engine_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_valid(rd_valid),
    .rd_addr (rd_addr),
    .rd_ready(rd_ready),
    .wr_valid(wr_valid),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_ready(wr_ready),
    .irq     (irq),
    .stat    (r_q.stat),
    .mask    (r_q.mask),
    .q_full  (q_full),
    .q_empty (q_empty),
    .cmd_push(cmd_push),
    .mv_done (mv_done),
    .mv_err  (mv_err)
);

// File: tb/tb_dmaq_engine.sv
module tb_dmaq_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq;
    logic        rd_valid, wr_valid;
    logic [31:0] rd_addr, wr_addr, wr_data, rd_data;
    logic        rd_ready = 1'b0, wr_ready = 1'b0;

    int nchk = 0, nfail = 0;
    int rdy_pct = 100;
    bit stall = 1'b0;
    bit          ev_k [4096];
    logic [31:0] ev_a [4096];
    logic [31:0] ev_d [4096];
    int ev_head = 0, ev_tail = 0;

    always #2 clk = ~clk;

    dmaq_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready)
    );

    function automatic logic [31:0] memval(logic [31:0] a);
        return a ^ {a[15:0], a[31:16]} ^ 32'hA5C3_0F17;
    endfunction

    assign rd_data = memval(rd_addr);

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_ev(bit k, logic [31:0] a, logic [31:0] d);
        ev_k[ev_tail] = k; ev_a[ev_tail] = a; ev_d[ev_tail] = d;
        ev_tail++;
    endtask

    // expected beats for one command, following R3..R7
    task automatic model_cmd(logic [31:0] src, logic [31:0] dst, logic [31:0] sl_raw,
                             logic [31:0] dl_raw, bit lb, output bit edone, output bit eerr);
        int s, d, ch;
        logic [31:0] sa, da;
        bit run;
        s = int'(sl_raw[26:0]) * 4; d = int'(dl_raw[26:0]) * 4;
        sa = src & ~32'd3; da = dst & ~32'd3;
        edone = 1'b0; eerr = 1'b0; run = 1'b1;
        while (run) begin
            if (s == 0 && d == 0) begin
                edone = 1'b1; run = 1'b0;
            end else begin
                ch = (s < 1024) ? s : 1024;
                if (lb && d < ch) ch = d;
                if (ch == 0) begin
                    eerr = 1'b1; run = 1'b0;
                end else begin
                    for (int i = 0; i < ch / 4; i++) push_ev(1'b0, sa + 32'(4 * i), memval(sa + 32'(4 * i)));
                    if (lb)
                        for (int i = 0; i < ch / 4; i++) push_ev(1'b1, da + 32'(4 * i), memval(sa + 32'(4 * i)));
                    sa += 32'(ch); s -= ch;
                    if (lb) begin da += 32'(ch); d -= ch; end
                end
            end
        end
    endtask

    // memory responder and beat monitor
    initial begin
        forever begin
            @(negedge clk);
            rd_ready = !stall && (($urandom % 100) < rdy_pct);
            wr_ready = !stall && (($urandom % 100) < rdy_pct);
            if (rst_n && rd_valid && rd_ready)
                chk(ev_head != ev_tail && !ev_k[ev_head] && rd_addr == ev_a[ev_head],
                    "R4 read beat order/address", rd_addr, ev_a[ev_head]);
            if (rst_n && wr_valid && wr_ready)
                chk(ev_head != ev_tail && ev_k[ev_head] && wr_addr == ev_a[ev_head]
                    && wr_data == ev_d[ev_head], "R5 write beat address/data", wr_data, ev_d[ev_head]);
            if (rst_n && ((rd_valid && rd_ready) || (wr_valid && wr_ready)) && ev_head != ev_tail)
                ev_head++;
        end
    end

    task automatic cfg_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic issue(logic [31:0] src, logic [31:0] dst, logic [31:0] sl, logic [31:0] dl,
                         bit lb, bit model, output bit edone, output bit eerr);
        edone = 1'b0; eerr = 1'b0;
        cfg_write(8'h1C, lb ? 32'h10 : 32'h0);
        cfg_write(8'h00, src);
        cfg_write(8'h04, dst);
        cfg_write(8'h08, sl);
        if (model) model_cmd(src, dst, sl, dl, lb, edone, eerr);
        cfg_write(8'h0C, dl);
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        int guard = 0;
        do begin
            cfg_read(8'h18, v);
            guard++;
        end while (!(v[30] && !rd_valid && !wr_valid) && guard < 60000);
        chk(ev_head == ev_tail, "R6 all expected beats seen in order", 32'(ev_head), 32'(ev_tail));
        ev_head = 0; ev_tail = 0;
    endtask

    task automatic finish_cmd(bit edone, bit eerr, string tag);
        logic [31:0] v;
        cfg_read(8'h10, v);
        chk(v[15:12] == {eerr, 1'b0, edone, edone}, tag, {28'd0, v[15:12]},
            {28'd0, eerr, 1'b0, edone, edone});
        cfg_write(8'h10, 32'h0000_F000);
    endtask

    initial begin
        #(4 * 190000);
        nfail++;
        $display("FAIL watchdog expired (R6 completion)");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] v, a0;
        bit ed, ee, lb;
        int sl, dl;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        cfg_read(8'h10, v); chk(v == 32'h8802_0000, "R1 status reset", v, 32'h8802_0000);
        cfg_read(8'h14, v); chk(v == 32'hFFFF_FFFF, "R1 mask reset", v, 32'hFFFF_FFFF);
        cfg_read(8'h18, v); chk(v == 32'h4000_0000, "R1 queue status reset", v, 32'h4000_0000);
        chk(irq == 1'b0, "R1 irq low", 32'(irq), 0);

        // R2 source length width
        cfg_write(8'h08, 32'hFFFF_FFFF);
        cfg_read(8'h08, v); chk(v == 32'h07FF_FFFF, "R2 source length bits", v, 32'h07FF_FFFF);

        // R3 R5 R6 without loopback: unaligned source, 3 words, no writes
        issue(32'h0000_1003, 32'h0000_2000, 32'd3, 32'd0, 1'b0, 1'b1, ed, ee);
        wait_idle();
        cfg_read(8'h10, v);
        chk(v == 32'h8802_3000, "R6 done bits set", v, 32'h8802_3000);
        chk(irq == 1'b0, "R10 irq masked", 32'(irq), 0);
        cfg_write(8'h14, ~(32'h1 << 13));
        chk(irq == 1'b1, "R10 irq open bit", 32'(irq), 1);
        cfg_write(8'h14, 32'hFFFF_FFFF);
        chk(irq == 1'b0, "R10 irq remasked", 32'(irq), 0);
        cfg_write(8'h10, 32'h0000_2000);
        cfg_read(8'h10, v);
        chk(v == 32'h8802_1000, "R9 write-one clears only that bit", v, 32'h8802_1000);
        cfg_write(8'h10, 32'h0000_1000);

        // R4 R5 loopback 300 words, unaligned destination, upper length bits dropped
        rdy_pct = 70;
        issue(32'h0000_4000, 32'h0000_8002, 32'd300, 32'hF800_012C, 1'b1, 1'b1, ed, ee);
        wait_idle();
        finish_cmd(ed, ee, "R4 two-piece loopback completes");
        cfg_read(8'h0C, v); chk(v == 32'h0000_012C, "R2 destination length bits", v, 32'h12C);

        // R7 mismatched lengths in loopback, both directions
        issue(32'h0000_3000, 32'h0000_3800, 32'd5, 32'd3, 1'b1, 1'b1, ed, ee);
        wait_idle();
        finish_cmd(ed, ee, "R7 source longer ends in error");
        chk(ee == 1'b1, "R7 model expects error", 32'(ee), 1);
        issue(32'h0000_3000, 32'h0000_3800, 32'd3, 32'd5, 1'b1, 1'b1, ed, ee);
        wait_idle();
        finish_cmd(ed, ee, "R7 destination longer ends in error");
        issue(32'h0000_5000, 32'h0000_6000, 32'd0, 32'd7, 1'b0, 1'b1, ed, ee);
        wait_idle();
        finish_cmd(ed, ee, "R7 destination length without loopback");

        // R6 zero-length command
        issue(32'h0000_5000, 32'h0000_6000, 32'd0, 32'd0, 1'b1, 1'b1, ed, ee);
        wait_idle();
        finish_cmd(ed, ee, "R6 zero-length completes");

        // R8 R11 overflow while memory stalls
        stall = 1'b1;
        for (int k = 0; k < 5; k++)
            issue(32'h0001_0000 + 32'(k * 64), 32'h0, 32'd2, 32'd0, 1'b0, k < 4, ed, ee);
        cfg_read(8'h18, v); chk(v == 32'h8000_0000, "R8 queue full", v, 32'h8000_0000);
        cfg_read(8'h10, v); chk(v[14] == 1'b1, "R8 overflow bit", v, 32'h8802_4000);
        a0 = rd_addr;
        repeat (5) @(negedge clk);
        chk(rd_valid && rd_addr == a0 && a0 == 32'h0001_0000, "R11 request held while stalled",
            rd_addr, 32'h0001_0000);
        stall = 1'b0;
        wait_idle();
        cfg_read(8'h10, v);
        chk(v[15:12] == 4'b0111, "R8 R6 four kept commands done, overflow kept", {28'd0, v[15:12]}, 32'h7);
        cfg_write(8'h10, 32'h0000_F000);

        // randomized commands
        for (int n = 0; n < 12; n++) begin
            lb = 1'($urandom % 2);
            sl = int'($urandom % 700);
            dl = lb ? sl : 0;
            rdy_pct = 30 + int'($urandom % 71);
            issue(32'h0002_0000 + ($urandom % 32'h1000), 32'h0008_0000 + ($urandom % 32'h1000),
                  32'(sl), 32'(dl), lb, 1'b1, ed, ee);
            wait_idle();
            finish_cmd(ed, ee, "R4 R5 R6 random command");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule